// File: doc/BRIEF.md
# Multiprocessor 9-bit UART port

This block is an asynchronous serial port with a byte-wide register interface. One address holds a control/status byte: the frame mode, a multiprocessor filter enable, a receive enable, the ninth bit to send, the ninth bit received, and two sticky completion flags. The other address holds the data buffer. A write to the data buffer starts a transmit frame. A read of it returns the last accepted received byte. Bit timing comes from an external tick that pulses sixteen times per bit period. A single interrupt line is high while either completion flag is set.

In the 9-bit modes the port supports multi-drop networks. When the filter enable is set, only frames whose ninth bit is 1 (address frames) are accepted. Frames with a ninth bit of 0 are discarded silently: the receive flag is not set, and the data buffer and the ninth-received-bit position are not updated. Software clears one flag by writing the control byte with a 0 in that flag's position and a 1 in the other. A hardware set in the same cycle is never lost.

The transmitter is a finite state machine with five states:

| State | Transitions |
|---|---|
| TX_IDLE | to TX_START on an accepted buffer write |
| TX_START | to TX_DATA after 16 ticks |
| TX_DATA | shifts one bit every 16 ticks; after the last data bit goes to TX_NINTH in a 9-bit frame, otherwise to TX_STOP |
| TX_NINTH | to TX_STOP after 16 ticks |
| TX_STOP | to TX_IDLE after 16 ticks, raising the done pulse |

The receiver is a finite state machine with five states:

| State | Transitions |
|---|---|
| RX_IDLE | to RX_START on a synchronized falling edge while reception is enabled |
| RX_START | back to RX_IDLE if the line is high at tick 8 (false start); otherwise to RX_DATA |
| RX_DATA | samples every 16 ticks; after eight bits goes to RX_NINTH or RX_STOP |
| RX_NINTH | captures the ninth bit, then goes to RX_STOP |
| RX_STOP | samples the stop bit, raises the done pulse and returns to RX_IDLE |

Top module: `mpuart_port`

## Requirements
- R1: After reset, the control byte (address 0) and the data buffer (address 1) both read 0x00, txd is 1 and irq is 0.
- R2: In mode 01 (control bits 7:6), a buffer write sends one 0 start bit, then 8 data bits LSB first, then one 1 stop bit. Each bit lasts 16 baud ticks, and txd is 1 while idle.
- R3: In modes 10 and 11, a 9th bit equal to control bit 3 (the ninth transmit bit) is sent between the data bits and the stop bit.
- R4: A buffer write is ignored while a frame is being sent, and is ignored in mode 00. In neither case does a frame start or change.
- R5: The transmit-done flag (control bit 1) is set at the end of the stop bit. irq equals the OR of control bits 1 and 0.
- R6: In mode 01, a completed reception loads the byte into the data buffer, sets the receive-done flag (control bit 0), and copies the received stop bit into control bit 2.
- R7: In modes 10 and 11, a completed reception copies the ninth received bit into control bit 2.
- R8: In a 9-bit mode with the multiprocessor enable (control bit 5) at 1, a frame whose ninth bit is 0 leaves control bit 0, control bit 2 and the data buffer unchanged. A frame whose ninth bit is 1 is accepted. In mode 01, bit 5 has no effect.
- R9: While the receive enable (control bit 4) is 0, no frame is received and the data buffer and control bit 0 stay unchanged.
- R10: A low pulse on rxd that is high again at the middle of the start bit is rejected. No flag is set, and the next valid frame is still received.
- R11: A control write stores bits 7:2 directly. On bits 1 and 0, a written 0 clears the flag and a written 1 leaves it unchanged.
- R12: If hardware sets a flag in the same cycle that a control write clears it, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | 0 selects the control byte, 1 the data buffer |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| baud_tick | input | 1 | One-cycle pulse, 16 per bit period |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |
| irq | output | 1 | High while either completion flag is set |

## Verification
A wrong transmitter state or bit counter appears on txd within one bit period: a wrong level at a bit centre, or a transmit-done flag set one bit too early or too late. Receiver faults appear once the stop bit has been sampled, as a wrong data buffer byte or a wrong control bit 2. Filter or enable faults appear as a receive flag that rises when it should not. Flag-update faults appear on irq in the cycle after the offending write.

// File: rtl/mpuart_pkg.sv
package mpuart_pkg;
    localparam int UART_DATA_W = 8;

    typedef enum logic [1:0] {
        MODE_SYNC  = 2'b00,
        MODE_8BIT  = 2'b01,
        MODE_9BIT  = 2'b10,
        MODE_9BITV = 2'b11
    } uart_mode_e;

    typedef struct packed {
        logic [UART_DATA_W-1:0] data;
        logic                   bit9;
        logic                   stop;
    } rx_frame_t;
endpackage

// File: rtl/mpuart_tx.sv
module mpuart_tx
    import mpuart_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   tick,
    input  logic                   start,
    input  logic                   nine,
    input  logic [UART_DATA_W-1:0] din,
    input  logic                   bit9_in,
    output logic                   txd,
    output logic                   busy,
    output logic                   done
);
    localparam int CW = $clog2(OVS);
    localparam int BW = $clog2(UART_DATA_W + 1);

    typedef enum logic [2:0] {
        TX_IDLE, TX_START, TX_DATA, TX_NINTH, TX_STOP
    } tx_state_e;

    tx_state_e              st_q, st_d;
    logic [CW-1:0]          cnt_q, cnt_d;
    logic [UART_DATA_W-1:0] sh_q, sh_d;
    logic [BW-1:0]          nb_q, nb_d;
    logic                   nine_q, nine_d;
    logic                   b9_q, b9_d;
    logic                   bit_end;

    assign bit_end = tick && (cnt_q == CW'(OVS - 1));

    always_comb begin
        st_d   = st_q;
        cnt_d  = cnt_q;
        sh_d   = sh_q;
        nb_d   = nb_q;
        nine_d = nine_q;
        b9_d   = b9_q;
        if (st_q != TX_IDLE && tick) begin
            cnt_d = bit_end ? '0 : cnt_q + 1'b1;
        end
        unique case (st_q)
            TX_IDLE: begin
                if (start) begin
                    st_d   = TX_START;
                    cnt_d  = '0;
                    sh_d   = din;
                    nb_d   = '0;
                    nine_d = nine;
                    b9_d   = bit9_in;
                end
            end
            TX_START: begin
                if (bit_end) st_d = TX_DATA;
            end
            TX_DATA: begin
                if (bit_end) begin
                    sh_d = sh_q >> 1;
                    nb_d = nb_q + 1'b1;
                    if (nb_q == BW'(UART_DATA_W - 1)) begin
                        st_d = nine_q ? TX_NINTH : TX_STOP;
                    end
                end
            end
            TX_NINTH: begin
                if (bit_end) st_d = TX_STOP;
            end
            TX_STOP: begin
                if (bit_end) st_d = TX_IDLE;
            end
            default: st_d = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= TX_IDLE;
            cnt_q  <= '0;
            sh_q   <= '0;
            nb_q   <= '0;
            nine_q <= 1'b0;
            b9_q   <= 1'b0;
        end else begin
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            sh_q   <= sh_d;
            nb_q   <= nb_d;
            nine_q <= nine_d;
            b9_q   <= b9_d;
        end
    end

    always_comb begin
        busy = (st_q != TX_IDLE);
        done = (st_q == TX_STOP) && bit_end;
        unique case (st_q)
            TX_IDLE:  txd = 1'b1;
            TX_START: txd = 1'b0;
            TX_DATA:  txd = sh_q[0];
            TX_NINTH: txd = b9_q;
            TX_STOP:  txd = 1'b1;
            default:  txd = 1'b1;
        endcase
    end
endmodule

// File: rtl/mpuart_rx.sv
module mpuart_rx
    import mpuart_pkg::*;
#(
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      enable,
    input  logic      nine,
    input  logic      rxd,
    output logic      busy,
    output logic      done,
    output rx_frame_t frame
);
    localparam int CW = $clog2(OVS);
    localparam int BW = $clog2(UART_DATA_W + 1);

    typedef enum logic [2:0] {
        RX_IDLE, RX_START, RX_DATA, RX_NINTH, RX_STOP
    } rx_state_e;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   rx_s;
    rx_state_e              st_q, st_d;
    logic [CW-1:0]          cnt_q, cnt_d;
    logic [UART_DATA_W-1:0] sh_q, sh_d;
    logic [BW-1:0]          nb_q, nb_d;
    logic                   nine_q, nine_d;
    logic                   b9_q, b9_d;
    logic                   half_pt, full_pt;

    assign rx_s    = sync_q[SYNC_STAGES-1];
    assign half_pt = tick && (cnt_q == CW'(OVS / 2 - 1));
    assign full_pt = tick && (cnt_q == CW'(OVS - 1));

    always_comb begin
        st_d   = st_q;
        cnt_d  = cnt_q;
        sh_d   = sh_q;
        nb_d   = nb_q;
        nine_d = nine_q;
        b9_d   = b9_q;
        if (st_q != RX_IDLE && tick) begin
            cnt_d = full_pt ? '0 : cnt_q + 1'b1;
        end
        unique case (st_q)
            RX_IDLE: begin
                if (enable && prev_q && !rx_s) begin
                    st_d   = RX_START;
                    cnt_d  = '0;
                    nb_d   = '0;
                    nine_d = nine;
                end
            end
            RX_START: begin
                if (half_pt) begin
                    cnt_d = '0;
                    st_d  = rx_s ? RX_IDLE : RX_DATA;
                end
            end
            RX_DATA: begin
                if (full_pt) begin
                    sh_d = {rx_s, sh_q[UART_DATA_W-1:1]};
                    nb_d = nb_q + 1'b1;
                    if (nb_q == BW'(UART_DATA_W - 1)) begin
                        st_d = nine_q ? RX_NINTH : RX_STOP;
                    end
                end
            end
            RX_NINTH: begin
                if (full_pt) begin
                    b9_d = rx_s;
                    st_d = RX_STOP;
                end
            end
            RX_STOP: begin
                if (full_pt) st_d = RX_IDLE;
            end
            default: st_d = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            prev_q <= 1'b1;
            st_q   <= RX_IDLE;
            cnt_q  <= '0;
            sh_q   <= '0;
            nb_q   <= '0;
            nine_q <= 1'b0;
            b9_q   <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], rxd};
            prev_q <= rx_s;
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            sh_q   <= sh_d;
            nb_q   <= nb_d;
            nine_q <= nine_d;
            b9_q   <= b9_d;
        end
    end

    always_comb begin
        busy       = (st_q != RX_IDLE);
        done       = (st_q == RX_STOP) && full_pt;
        frame.data = sh_q;
        frame.bit9 = b9_q;
        frame.stop = rx_s;
    end
endmodule

// File: rtl/mpuart_regs.sv
module mpuart_regs
    import mpuart_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_wr,
    input  logic                   bus_addr,
    input  logic [7:0]             bus_wdata,
    output logic [7:0]             bus_rdata,
    input  logic                   tx_done,
    input  logic                   rx_done,
    input  rx_frame_t              rx_frame,
    output logic                   tx_start,
    output logic                   nine_mode,
    output logic                   tb9,
    output logic                   rx_en,
    output logic                   mpe,
    output logic                   ti,
    output logic                   ri,
    output logic [UART_DATA_W-1:0] tx_byte
);
    uart_mode_e             mode_q;
    logic                   ren_q;
    logic                   rb8_q;
    logic [UART_DATA_W-1:0] rbuf_q;
    logic                   wr_ctrl, wr_data, accept;

    assign wr_ctrl   = bus_wr && !bus_addr;
    assign wr_data   = bus_wr && bus_addr;
    assign nine_mode = mode_q[1];
    assign accept    = rx_done && (!nine_mode || !mpe || rx_frame.bit9);
    assign tx_start  = wr_data && (mode_q != MODE_SYNC);
    assign rx_en     = ren_q && (mode_q != MODE_SYNC);
    assign tx_byte   = bus_wdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_SYNC;
            mpe    <= 1'b0;
            ren_q  <= 1'b0;
            tb9    <= 1'b0;
            rb8_q  <= 1'b0;
            ti     <= 1'b0;
            ri     <= 1'b0;
            rbuf_q <= '0;
        end else begin
            if (wr_ctrl) begin
                mode_q <= uart_mode_e'(bus_wdata[7:6]);
                mpe    <= bus_wdata[5];
                ren_q  <= bus_wdata[4];
                tb9    <= bus_wdata[3];
                rb8_q  <= bus_wdata[2];
            end
            ti <= tx_done || (ti && (!wr_ctrl || bus_wdata[1]));
            ri <= accept  || (ri && (!wr_ctrl || bus_wdata[0]));
            if (accept) begin
                rbuf_q <= rx_frame.data;
                rb8_q  <= nine_mode ? rx_frame.bit9 : rx_frame.stop;
            end
        end
    end

    always_comb begin
        if (bus_addr) bus_rdata = rbuf_q;
        else          bus_rdata = {mode_q, mpe, ren_q, tb9, rb8_q, ti, ri};
    end
endmodule

// File: rtl/mpuart_port.sv
module mpuart_port
    import mpuart_pkg::*;
#(
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_wr,
    input  logic       bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       baud_tick,
    output logic       txd,
    input  logic       rxd,
    output logic       irq
);
    logic                   tx_start, tx_busy, tx_done;
    logic                   rx_busy, rx_done;
    logic                   nine_mode, tb9, rx_en, mpe, ti, ri;
    logic [UART_DATA_W-1:0] tx_byte;
    rx_frame_t              rx_frame;

    mpuart_regs u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_done(tx_done),
        .rx_done(rx_done), .rx_frame(rx_frame), .tx_start(tx_start),
        .nine_mode(nine_mode), .tb9(tb9), .rx_en(rx_en), .mpe(mpe),
        .ti(ti), .ri(ri), .tx_byte(tx_byte)
    );

    mpuart_tx #(.OVS(OVS)) u_tx (
        .clk(clk), .rst_n(rst_n), .tick(baud_tick), .start(tx_start),
        .nine(nine_mode), .din(tx_byte), .bit9_in(tb9), .txd(txd),
        .busy(tx_busy), .done(tx_done)
    );

    mpuart_rx #(.OVS(OVS), .SYNC_STAGES(SYNC_STAGES)) u_rx (
        .clk(clk), .rst_n(rst_n), .tick(baud_tick), .enable(rx_en),
        .nine(nine_mode), .rxd(rxd), .busy(rx_busy), .done(rx_done),
        .frame(rx_frame)
    );

    assign irq = ti || ri;
endmodule

// File: rtl/mpuart_chk.sv
module mpuart_chk (
    input logic clk,
    input logic rst_n,
    input logic bus_wr,
    input logic bus_addr,
    input logic txd,
    input logic irq,
    input logic tx_busy,
    input logic tx_done,
    input logic tx_start,
    input logic rx_busy,
    input logic rx_done,
    input logic rx_bit9,
    input logic rx_en,
    input logic nine_mode,
    input logic mpe,
    input logic ti,
    input logic ri
);
    // R2: line rests high between frames
    p_idle_line_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> txd);

    // R4: a frame only begins after an accepted buffer write
    p_tx_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy) |-> $past(bus_wr && bus_addr && tx_start));

    // R9: receiver leaves idle only while reception is enabled
    p_ren_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_busy) |-> $past(rx_en));

    // R8: filtered data frame never raises the receive flag
    p_addr_filter_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && nine_mode && mpe && !rx_bit9) |=> !$rose(ri));

    // R11: interrupt drops only after a control write
    p_flag_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(bus_wr && !bus_addr));

    // R12: completion always leaves the transmit flag set
    p_set_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |=> ti);
endmodule

bind mpuart_port mpuart_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .txd(txd), .irq(irq), .tx_busy(tx_busy), .tx_done(tx_done),
    .tx_start(tx_start), .rx_busy(rx_busy), .rx_done(rx_done),
    .rx_bit9(rx_frame.bit9), .rx_en(rx_en), .nine_mode(nine_mode),
    .mpe(mpe), .ti(ti), .ri(ri)
);

// File: tb/mpuart_port_bench.sv
`timescale 1ns/1ps
module mpuart_port_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_addr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       baud_tick = 1'b1;
    logic       txd;
    logic       rxd;
    logic       irq;
    logic       loop = 1'b1;
    logic       rx_drv = 1'b1;
    int         n_cmp = 0;
    int         n_bad = 0;

    assign rxd = loop ? txd : rx_drv;

    always #2.5 clk = ~clk;

    mpuart_port u_mpuart_port (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .baud_tick(baud_tick),
        .txd(txd), .rxd(rxd), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic a, output logic [7:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    function automatic logic [7:0] cv(input logic [1:0] m, input logic mp, input logic re,
                                      input logic t9, input logic kti, input logic kri);
        return {m, mp, re, t9, 1'b0, kti, kri};
    endfunction

    // Send one frame in loopback and check every bit centre plus the results.
    task automatic tx_frame(input logic [7:0] d, input logic nine, input logic b9);
        int n;
        logic [7:0] r;
        logic exp_bit;
        n = nine ? 11 : 10;
        wr_reg(1'b1, d);
        for (int k = 0; k < n; k++) begin
            repeat (8) @(negedge clk);
            if (k == 0) exp_bit = 1'b0;
            else if (k <= 8) exp_bit = d[k-1];
            else if (nine && k == 9) exp_bit = b9;
            else exp_bit = 1'b1;
            if (nine && k == 9) chk("R3 ninth bit", txd, exp_bit);
            else chk("R2 tx bit", txd, exp_bit);
            repeat (8) @(negedge clk);
        end
        chk("R5 irq after frame", irq, 1'b1);
        rd_reg(1'b0, r);
        chk("R5 transmit flag", r[1], 1'b1);
        chk("R6 receive flag", r[0], 1'b1);
        if (nine) chk("R7 ninth received", r[2], b9);
        else chk("R6 stop into bit2", r[2], 1'b1);
        rd_reg(1'b1, r);
        chk("R6 rx buffer", r, d);
    endtask

    task automatic send(input logic [7:0] d, input logic nine, input logic b9, input logic stp);
        rx_drv = 1'b0; repeat (16) @(negedge clk);
        for (int k = 0; k < 8; k++) begin
            rx_drv = d[k]; repeat (16) @(negedge clk);
        end
        if (nine) begin
            rx_drv = b9; repeat (16) @(negedge clk);
        end
        rx_drv = stp; repeat (16) @(negedge clk);
        rx_drv = 1'b1; repeat (30) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] r;
        logic [1:0] m;
        logic       p;
        int         hi;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd_reg(1'b0, r); chk("R1 ctrl reset", r, 8'h00);
        rd_reg(1'b1, r); chk("R1 buffer reset", r, 8'h00);
        chk("R1 txd idle", txd, 1'b1);
        chk("R1 irq reset", irq, 1'b0);

        // R11 direct fields and flags ignore ones
        wr_reg(1'b0, 8'hB8); rd_reg(1'b0, r); chk("R11 readback", r, 8'hB8);
        wr_reg(1'b0, 8'h47); rd_reg(1'b0, r); chk("R11 ones ignored", r, 8'h44);
        chk("R11 irq low", irq, 1'b0);

        // R2/R5/R6 sweep in 8-bit mode
        wr_reg(1'b0, cv(2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0));
        for (int d = 0; d < 256; d++) begin
            tx_frame(8'(d), 1'b0, 1'b0);
            wr_reg(1'b0, cv(2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0));
            chk("R5 irq cleared", irq, 1'b0);
        end

        // R3/R7 sweep in both 9-bit modes
        for (int d = 0; d < 256; d++) begin
            m = d[1] ? 2'b11 : 2'b10;
            p = d[0] ^ d[7] ^ d[4];
            wr_reg(1'b0, cv(m, 1'b0, 1'b1, p, 1'b0, 1'b0));
            tx_frame(8'(d), 1'b1, p);
        end

        // R11 mask clears exactly one flag
        wr_reg(1'b0, cv(2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0));
        tx_frame(8'h96, 1'b0, 1'b0);
        wr_reg(1'b0, cv(2'b01, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0));
        rd_reg(1'b0, r); chk("R11 clear rx only", r[1:0], 2'b10);
        wr_reg(1'b0, cv(2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1));
        rd_reg(1'b0, r); chk("R11 clear tx", r[1:0], 2'b00);

        // R4 write while busy
        wr_reg(1'b1, 8'h5A);
        repeat (40) @(negedge clk);
        wr_reg(1'b1, 8'hC3);
        repeat (140) @(negedge clk);
        rd_reg(1'b1, r); chk("R4 busy write ignored", r, 8'h5A);
        wr_reg(1'b0, cv(2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0));
        hi = 0;
        for (int c = 0; c < 250; c++) begin
            @(negedge clk);
            if (txd) hi++;
        end
        chk("R4 no second frame", hi, 250);
        chk("R4 no flag", irq, 1'b0);

        // R4 mode 00 ignores buffer writes
        wr_reg(1'b0, cv(2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0));
        wr_reg(1'b1, 8'h00);
        hi = 0;
        for (int c = 0; c < 200; c++) begin
            @(negedge clk);
            if (txd) hi++;
        end
        chk("R4 mode00 line idle", hi, 200);
        chk("R4 mode00 no flag", irq, 1'b0);

        // R12 hardware set wins over same-cycle clear
        wr_reg(1'b0, cv(2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0));
        wr_reg(1'b1, 8'hA5);
        repeat (158) @(negedge clk);
        wr_reg(1'b0, cv(2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0));
        rd_reg(1'b0, r);
        chk("R12 set wins", r[1:0], 2'b10);
        wr_reg(1'b0, cv(2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0));

        // Direct receive cases
        loop = 1'b0;
        repeat (5) @(negedge clk);
        send(8'h3C, 1'b0, 1'b0, 1'b0);
        rd_reg(1'b1, r); chk("R6 direct byte", r, 8'h3C);
        rd_reg(1'b0, r); chk("R6 stop 0 into bit2", r[2:0], 3'b001);

        wr_reg(1'b0, cv(2'b11, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0));
        send(8'h77, 1'b1, 1'b0, 1'b1);
        rd_reg(1'b0, r); chk("R8 data frame filtered", r[2:0], 3'b000);
        rd_reg(1'b1, r); chk("R8 buffer kept", r, 8'h3C);
        send(8'h21, 1'b1, 1'b1, 1'b1);
        rd_reg(1'b0, r); chk("R8 address accepted", r[2:0], 3'b101);
        rd_reg(1'b1, r); chk("R8 address byte", r, 8'h21);

        wr_reg(1'b0, cv(2'b01, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0));
        send(8'h99, 1'b0, 1'b0, 1'b1);
        rd_reg(1'b1, r); chk("R8 8-bit ignores enable", r, 8'h99);
        chk("R8 8-bit flag", irq, 1'b1);

        wr_reg(1'b0, cv(2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
        send(8'hE7, 1'b0, 1'b0, 1'b1);
        rd_reg(1'b1, r); chk("R9 disabled buffer", r, 8'h99);
        chk("R9 disabled flag", irq, 1'b0);

        wr_reg(1'b0, cv(2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0));
        rx_drv = 1'b0; repeat (4) @(negedge clk);
        rx_drv = 1'b1; repeat (100) @(negedge clk);
        chk("R10 glitch rejected", irq, 1'b0);
        send(8'h42, 1'b0, 1'b0, 1'b1);
        rd_reg(1'b1, r); chk("R10 next frame", r, 8'h42);
        chk("R10 next flag", irq, 1'b1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule